// File: doc/BRIEF.md
# Serial Audio Transmitter (Clock Master)

This block drives a three-wire serial audio link as its clock master. It generates a bit clock, a left/right word clock and a serial data line, and it takes stereo sample pairs from a small FIFO. Logic upstream pushes a left and a right sample in the same cycle. The serializer takes one pair from the FIFO at the start of every stereo frame and sends the left sample in the first half of the frame and the right sample in the second half.

Static control inputs set the behaviour:
- the justification format: standard, MSB-aligned or LSB-aligned;
- which channel is sent while the word clock is low;
- the sample width: 8, 16 or 24 bits;
- the frame length: 16, 24, 32 or 48 bit clocks.

If a frame starts while the FIFO is empty, the block sends silence and sets a sticky underrun flag, which can raise an interrupt. A pause input idles the serializer at frame granularity and keeps the FIFO contents.

Top module: `audio_ser_tx`

## Requirements
- R1: The bit clock `sck` is low in reset. It toggles every `SCK_HALF` clock cycles. `ws` and `sd` change only in the cycle in which `sck` falls. A frame lasts 32, 48, 16 or 24 bit clocks for `ratio_sel` 0, 1, 2 or 3.
- R2: Each frame carries two channels, left in the first half and right in the second. `ws` equals `lr_swap` during the left half and the inverse of `lr_swap` during the right half.
- R3: For `fmt_sel`=0 the MSB is in slot 1 of each half. For `fmt_sel`=1 the MSB is in slot 0. For `fmt_sel`=2 the LSB is in the last slot of each half. Slots that carry no sample bit are driven low.
- R4: `width_sel` 0, 1 and 2 select 16, 8 and 24 bits. The sample is the low W bits of the pushed word, and it is sent MSB first.
- R5: `push` stores a pair while the FIFO is not full. `fifo_full` is set at `FIFO_DEPTH` pairs. A push while full is dropped. Pairs leave in push order, one at each active frame start.
- R6: An active frame that starts with the FIFO empty sends all zeros and sets `urun_flag`. The flag stays set until `urun_clr`. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly when `urun_flag` and `urun_ie` are both high.
- R8: `pause` is sampled at each frame start. A paused frame sends zeros, takes nothing from the FIFO and raises no underrun. After `pause` is released, the next frame start sends the FIFO head.
- R9: After reset, `ws`, `sd`, `fifo_full`, `urun_flag` and `irq` are low and `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 2 | Justification: 0 standard, 1 MSB-aligned, 2 LSB-aligned |
| lr_swap | input | 1 | 0: left sent with ws low; 1: right sent with ws low |
| width_sel | input | 2 | Sample width: 0 = 16, 1 = 8, 2 = 24 bits |
| ratio_sel | input | 2 | Bit clocks per frame: 0 = 32, 1 = 48, 2 = 16, 3 = 24 |
| pause | input | 1 | Idle the serializer from the next frame start |
| push | input | 1 | Write one stereo pair |
| push_left | input | 24 | Left sample, right-aligned |
| push_right | input | 24 | Right sample, right-aligned |
| fifo_empty | output | 1 | FIFO holds no pair |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH pairs |
| urun_ie | input | 1 | Underrun interrupt enable |
| urun_clr | input | 1 | Clear the underrun flag |
| urun_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word clock |
| sd | output | 1 | Serial data |

## Verification
Setting the underrun flag and clearing it by software can fall in the same cycle, because the flag is set on a frame-start edge. The bench holds `urun_clr` high across several underrun frame starts with an empty FIFO. It then counts the cycles in which `urun_flag` and `irq` are high. Exactly one high cycle per frame start shows that the set took priority and that the clear took effect one cycle later.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int FIFO_DEPTH = 4,
  parameter int SCK_HALF   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt_sel,
  input  logic        lr_swap,
  input  logic [1:0]  width_sel,
  input  logic [1:0]  ratio_sel,
  input  logic        pause,
  input  logic        push,
  input  logic [23:0] push_left,
  input  logic [23:0] push_right,
  output logic        fifo_empty,
  output logic        fifo_full,
  input  logic        urun_ie,
  input  logic        urun_clr,
  output logic        urun_flag,
  output logic        irq,
  output logic        sck,
  output logic        ws,
  output logic        sd
);
  // FIFO_DEPTH must be a power of two
  localparam int SW = 24;
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [2*SW-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW:0]     count;
  logic [CW-1:0]   div_cnt;
  logic [5:0]      pos, pos_n, frame_len, half_len, slot, width, k;
  logic [4:0]      idx;
  logic [SW-1:0]   cur_l, cur_r, load_l, load_r;
  logic [31:0]     samp;
  logic            running, run_n, tick, frame_start, second, valid, sd_n;
  logic            do_push, do_pop, urun_set;

  assign fifo_empty = (count == '0);
  assign fifo_full  = (count == (AW+1)'(FIFO_DEPTH));
  assign do_push    = push && !fifo_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      sck     <= 1'b0;
    end else if (div_cnt == CW'(SCK_HALF - 1)) begin
      div_cnt <= '0;
      sck     <= ~sck;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end

  assign tick = sck && (div_cnt == CW'(SCK_HALF - 1));

  always_comb begin
    case (ratio_sel)
      2'd0:    frame_len = 6'd32;
      2'd1:    frame_len = 6'd48;
      2'd2:    frame_len = 6'd16;
      default: frame_len = 6'd24;
    endcase
    case (width_sel)
      2'd1:    width = 6'd8;
      2'd2:    width = 6'd24;
      default: width = 6'd16;
    endcase
  end

  assign half_len    = frame_len >> 1;
  assign pos_n       = (pos >= frame_len - 6'd1) ? '0 : pos + 6'd1;
  assign frame_start = (pos_n == '0);
  assign second      = (pos_n >= half_len);
  assign slot        = second ? pos_n - half_len : pos_n;
  assign run_n       = frame_start ? !pause : running;
  assign do_pop      = tick && frame_start && run_n && !fifo_empty;
  assign urun_set    = tick && frame_start && run_n && fifo_empty;

  assign load_l = !frame_start ? cur_l :
                  (run_n && !fifo_empty) ? mem[rd_ptr][2*SW-1:SW] : '0;
  assign load_r = !frame_start ? cur_r :
                  (run_n && !fifo_empty) ? mem[rd_ptr][SW-1:0] : '0;
  assign samp   = {8'd0, (second ? load_r : load_l)};

  always_comb begin
    case (fmt_sel)
      2'd1: begin
        k     = slot;
        valid = (k < width);
        idx   = 5'(width - 6'd1 - k);
      end
      2'd2: begin
        k     = half_len - 6'd1 - slot;
        valid = (k < width);
        idx   = 5'(k);
      end
      default: begin
        k     = slot - 6'd1;
        valid = (slot != '0) && (k < width);
        idx   = 5'(width - 6'd1 - k);
      end
    endcase
    sd_n = run_n && valid && samp[idx];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos     <= 6'h3f;
      running <= 1'b0;
      ws      <= 1'b0;
      sd      <= 1'b0;
      cur_l   <= '0;
      cur_r   <= '0;
    end else if (tick) begin
      pos     <= pos_n;
      running <= run_n;
      ws      <= second ^ lr_swap;
      sd      <= sd_n;
      if (frame_start) begin
        cur_l <= load_l;
        cur_r <= load_r;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= {push_left, push_right};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        urun_flag <= 1'b0;
    else if (urun_set) urun_flag <= 1'b1;
    else if (urun_clr) urun_flag <= 1'b0;

  assign irq = urun_flag && urun_ie;
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int SCK_HALF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic fifo_empty,
  input logic fifo_full,
  input logic urun_flag,
  input logic urun_clr,
  input logic running
);
  logic        sck_q;
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      gap   <= '0;
    end else begin
      sck_q <= sck;
      gap   <= (sck != sck_q) ? 16'd1 : gap + 16'd1;
    end

  a_r1_sck_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != sck_q) |-> (gap == 16'(SCK_HALF)));

  a_r1_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(sck));

  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(sck));

  a_r5_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !fifo_empty);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_full, fifo_empty}));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_flag && !urun_clr) |=> urun_flag);

  a_r6_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun_flag) |-> ($fell(sck) && $past(fifo_empty)));

  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sd);
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.SCK_HALF(SCK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .urun_flag(urun_flag), .urun_clr(urun_clr), .running(running)
);

// File: tb/test_audio_ser_tx.sv
`timescale 1ns/1ps
module test_audio_ser_tx;
  localparam int DEPTH = 4;
  localparam int HALF  = 4;
  localparam int NV    = 8;
  // {fmt, swap, width_sel, ratio_sel, left, right}
  localparam logic [54:0] VEC [NV] = '{
    {2'd0, 1'b0, 2'd0, 2'd0, 24'h00A5C3, 24'h003C5A},
    {2'd1, 1'b0, 2'd0, 2'd0, 24'h00F00F, 24'h001234},
    {2'd2, 1'b1, 2'd0, 2'd0, 24'h008001, 24'h00ABCD},
    {2'd0, 1'b1, 2'd2, 2'd1, 24'hC35A96, 24'h81F00E},
    {2'd2, 1'b0, 2'd2, 2'd1, 24'h9ABCDE, 24'h102030},
    {2'd1, 1'b1, 2'd1, 2'd2, 24'h0000B7, 24'h00004D},
    {2'd0, 1'b0, 2'd1, 2'd3, 24'h0000E1, 24'h00001E},
    {2'd2, 1'b0, 2'd1, 2'd2, 24'h000096, 24'h000069}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] fmt_sel = 0, width_sel = 0, ratio_sel = 0;
  logic lr_swap = 0, pause = 0, push = 0, urun_ie = 0, urun_clr = 0;
  logic [23:0] push_left = 0, push_right = 0;
  logic fifo_empty, fifo_full, urun_flag, irq, sck, ws, sd;

  int checks = 0, errors = 0;
  int ecount;
  logic cap_sd [4096];
  logic cap_ws [4096];

  always #2 clk = ~clk;

  audio_ser_tx #(.FIFO_DEPTH(DEPTH), .SCK_HALF(HALF)) i_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .lr_swap(lr_swap),
    .width_sel(width_sel), .ratio_sel(ratio_sel), .pause(pause),
    .push(push), .push_left(push_left), .push_right(push_right),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .urun_ie(urun_ie),
    .urun_clr(urun_clr), .urun_flag(urun_flag), .irq(irq),
    .sck(sck), .ws(ws), .sd(sd));

  always @(posedge sck or negedge rst_n)
    if (!rst_n) ecount <= 0;
    else begin
      if (ecount < 4096) begin
        cap_sd[ecount] <= sd;
        cap_ws[ecount] <= ws;
      end
      ecount <= ecount + 1;
    end

  function automatic int wbits(logic [1:0] s);
    return (s == 2'd1) ? 8 : (s == 2'd2) ? 24 : 16;
  endfunction
  function automatic int flen(logic [1:0] s);
    case (s) 2'd0: return 32; 2'd1: return 48; 2'd2: return 16; default: return 24; endcase
  endfunction
  function automatic logic exp_bit(int f, int w, int h, int s, logic [23:0] v);
    int k;
    if (f == 1) begin k = s; return (k < w) ? v[w-1-k] : 1'b0; end
    if (f == 2) begin k = h - 1 - s; return (k < w) ? v[k] : 1'b0; end
    k = s - 1;
    return (s >= 1 && k < w) ? v[w-1-k] : 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_frame(int f, logic [23:0] l, logic [23:0] r, string tag);
    int fl = flen(ratio_sel);
    int h = fl / 2;
    for (int half = 0; half < 2; half++) begin
      logic [23:0] got = 0, exp = 0;
      logic [23:0] wgot = 0, wexp = 0;
      for (int s = 0; s < h; s++) begin
        int e = 1 + f * fl + half * h + s;
        got[h-1-s]  = cap_sd[e];
        exp[h-1-s]  = exp_bit(int'(fmt_sel), wbits(width_sel), h, s, half ? r : l);
        wgot[h-1-s] = cap_ws[e];
        wexp[h-1-s] = lr_swap ^ half[0];
      end
      chk(got == exp, {tag, " R3 R4 data"}, 32'(got), 32'(exp));
      chk(wgot == wexp, {tag, " R2 ws"}, 32'(wgot), 32'(wexp));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    push = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_edges(int n);
    while (ecount < n) @(negedge clk);
  endtask

  task automatic push_pair(logic [23:0] l, logic [23:0] r);
    push = 1; push_left = l; push_right = r;
    @(negedge clk);
    push = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fl, f0, cnt_f, cnt_i;
    logic [23:0] l2, r2;

    // reset state (R9) and bit clock rate (R1)
    urun_ie = 1;
    do_reset();
    @(posedge clk); #1;
    chk(!sck && !ws && !sd, "R9 lines low", {sck, ws, sd}, 0);
    chk(fifo_empty && !fifo_full, "R9 fifo flags", {fifo_empty, fifo_full}, 2'b10);
    chk(!urun_flag && !irq, "R9 underrun", {urun_flag, irq}, 0);
    pause = 1;
    @(negedge clk);
    repeat (79) @(negedge clk);
    chk(ecount == 10, "R1 bit clock period", ecount, 10);
    pause = 0;
    urun_ie = 0;

    // vector table: two frames then an underrun frame
    for (int v = 0; v < NV; v++) begin
      fmt_sel   = VEC[v][54:53];
      lr_swap   = VEC[v][52];
      width_sel = VEC[v][51:50];
      ratio_sel = VEC[v][49:48];
      l2 = {VEC[v][35:24], VEC[v][47:36]} ^ 24'h5A5A5A;
      r2 = ~VEC[v][23:0];
      fl = flen(ratio_sel);
      do_reset();
      push_pair(VEC[v][47:24], VEC[v][23:0]);
      push_pair(l2, r2);
      wait_edges(3 * fl + 1);
      chk_frame(0, VEC[v][47:24], VEC[v][23:0], "R1 R5 frame0");
      chk_frame(1, l2, r2, "R5 frame1");
      chk_frame(2, 24'd0, 24'd0, "R6 underrun frame");
      chk(urun_flag, "R6 flag set", urun_flag, 1);
      chk(!irq, "R7 irq masked", irq, 0);
      chk(fifo_empty, "R5 drained", fifo_empty, 1);
    end

    // R7 enable, then R6 sticky/clear with R8 stopping new underruns
    urun_ie = 1;
    @(negedge clk);
    chk(irq, "R7 irq enabled", irq, 1);
    pause = 1;
    wait_edges(ecount + 2 * fl);
    chk(urun_flag, "R6 sticky", urun_flag, 1);
    urun_clr = 1;
    @(negedge clk);
    urun_clr = 0;
    chk(!urun_flag && !irq, "R6 cleared", {urun_flag, irq}, 0);
    wait_edges(ecount + 2 * fl);
    chk(!urun_flag, "R8 no underrun while paused", urun_flag, 0);

    // R5 full/drop and R8 pause-resume
    fmt_sel = 0; lr_swap = 0; width_sel = 0; ratio_sel = 0; fl = 32;
    urun_ie = 0;
    pause = 1;
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++)
      push_pair(24'h1000 + 24'(i * 24'h0123), 24'h8000 ^ 24'(i));
    chk(fifo_full && !fifo_empty, "R5 full", {fifo_full, fifo_empty}, 2'b10);
    wait_edges(1 + 3 * fl);
    chk(fifo_full, "R8 pause keeps fifo", fifo_full, 1);
    chk(!urun_flag, "R8 pause no underrun", urun_flag, 0);
    chk_frame(1, 24'd0, 24'd0, "R8 paused silent");
    while (((ecount - 1) % fl) != 2) @(negedge clk);
    f0 = (ecount - 1) / fl;
    pause = 0;
    wait_edges(1 + (f0 + 6) * fl);
    chk_frame(f0, 24'd0, 24'd0, "R8 frame before resume");
    for (int i = 0; i < DEPTH; i++)
      chk_frame(f0 + 1 + i, 24'h1000 + 24'(i * 24'h0123), 24'h8000 ^ 24'(i), "R8 R5 resumed order");
    chk_frame(f0 + 1 + DEPTH, 24'd0, 24'd0, "R5 dropped push not sent");
    chk(urun_flag, "R6 underrun after drain", urun_flag, 1);

    // set-versus-clear collision (R6, R7)
    ratio_sel = 2; width_sel = 1; fl = 16;
    pause = 0; urun_clr = 1; urun_ie = 1;
    do_reset();
    cnt_f = 0; cnt_i = 0;
    while (ecount < 2 * fl + 2) begin
      @(negedge clk);
      if (urun_flag) cnt_f++;
      if (irq) cnt_i++;
    end
    chk(cnt_f == 3, "R6 set wins over clear", cnt_f, 3);
    chk(cnt_i == 3, "R7 irq follows flag", cnt_i, 3);
    urun_clr = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule